// File: doc/BRIEF.md
# Interrupt Source Collector with Watermark and Event Sources

This block gathers the interrupt sources of a memory-mapped bus controller peripheral and drives them onto one active-high, level-type interrupt line. It has six sources of two kinds. Three are watermark sources, which are worked out again every cycle from a FIFO fill level and its watermark. They clear themselves once the level moves back across the watermark. The other three are sticky event sources. A strobe from the receipt stream, the in-band-interrupt stream or the address-assignment stream sets one of them, and it stays set until software clears it.

A small read/write port takes the place of the register bus. It selects one of two registers. The mask register enables sources onto the interrupt line. The pending register shows the raw state of every source and clears event bits on a write of one. The FIFOs and the bus protocol are not part of this block. Their fill levels, watermarks and arrival strobes come in as plain inputs.

Top module: `irq_collector`

## Requirements
- R1: `irq` is high exactly when some source bit of the pending register is 1 and the same bit of the mask register is 1. It follows the register contents with no added cycle of delay.
- R2: Pending bit 0 (transmit almost-empty) is 1 one clock after `tx_level` is strictly below `tx_empty_mark`, and is 0 one clock after `tx_level` is equal to or above it.
- R3: Pending bit 1 (receive almost-full) is 1 one clock after `rx_level` > `rx_full_mark`. Pending bit 2 (in-band-interrupt data almost-full) is 1 one clock after `ibi_level` > `ibi_full_mark`. An equal level gives 0.
- R4: Watermark bits 0 to 2 clear by themselves when the level crosses back over the watermark. Writing ones to those bits of the pending register has no effect on them.
- R5: A one-cycle `receipt_evt` pulse sets pending bit 3 on the next clock.
- R6: A one-cycle `ibi_evt` pulse sets pending bit 4 on the next clock.
- R7: A one-cycle `addr_req_evt` pulse sets pending bit 5 on the next clock.
- R8: Event bits 3 to 5 hold their value until a pending write (`reg_sel`=1) has a 1 in that bit position. A 0 in that position leaves the bit unchanged.
- R9: When a new event and a clear of the same bit reach the same clock edge, the bit stays 1.
- R10: With `reg_sel`=1, `reg_rdata` returns the raw pending state, whatever the mask. With `reg_sel`=0, it returns the mask, which a write with `reg_sel`=0 loads.
- R11: A synchronous active-low reset clears the mask, clears every pending bit and holds `irq` low. At reset every source is masked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all state |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_level | input | LVL_W | Transmit FIFO fill level |
| tx_empty_mark | input | LVL_W | Transmit almost-empty watermark |
| rx_level | input | LVL_W | Receive FIFO fill level |
| rx_full_mark | input | LVL_W | Receive almost-full watermark |
| ibi_level | input | LVL_W | In-band-interrupt FIFO fill level |
| ibi_full_mark | input | LVL_W | In-band-interrupt almost-full watermark |
| receipt_evt | input | 1 | New command receipt strobe |
| ibi_evt | input | 1 | New in-band-interrupt record strobe |
| addr_req_evt | input | 1 | Address requested during dynamic assignment |
| reg_sel | input | 1 | Register select: 0 mask, 1 pending |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 6 | Write data, one bit per source |
| reg_rdata | output | 6 | Read data of the selected register |
| irq | output | 1 | Active-high level interrupt |

## Verification
The assertions assume that levels and watermarks are plain unsigned numbers that may change in any cycle, and that event strobes may come at the same time as each other or as a pending write. The assertions compare each pending bit with the inputs of the cycle before. For this reason the stimulus changes inputs only between clock edges and holds each value across at least one edge. The bench also drives a coinciding event and clear, and equal-to-watermark levels, so that the boundary cases happen at the ports.

// File: rtl/irq_collector.sv
module irq_collector #(
  parameter int LVL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] tx_level,
  input  logic [LVL_W-1:0] tx_empty_mark,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] rx_full_mark,
  input  logic [LVL_W-1:0] ibi_level,
  input  logic [LVL_W-1:0] ibi_full_mark,
  input  logic             receipt_evt,
  input  logic             ibi_evt,
  input  logic             addr_req_evt,
  input  logic             reg_sel,
  input  logic             reg_wr,
  input  logic [5:0]       reg_wdata,
  output logic [5:0]       reg_rdata,
  output logic             irq
);
  localparam int NLVL = 3;
  localparam int NEVT = 3;
  localparam int NSRC = NLVL + NEVT;

  logic [NLVL-1:0] lvl_now, lvl_q;
  logic [NEVT-1:0] evt_in, evt_clr, evt_q;
  logic [NSRC-1:0] mask_q, src;
  logic            pend_wr, mask_wr;

  assign lvl_now = {ibi_level > ibi_full_mark, rx_level > rx_full_mark, tx_level < tx_empty_mark};
  assign evt_in  = {addr_req_evt, ibi_evt, receipt_evt};
  assign pend_wr = reg_wr & reg_sel;
  assign mask_wr = reg_wr & ~reg_sel;
  assign evt_clr = pend_wr ? reg_wdata[NSRC-1:NLVL] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_q  <= '0;
      evt_q  <= '0;
      mask_q <= '0;
    end else begin
      lvl_q <= lvl_now;
      evt_q <= evt_in | (evt_q & ~evt_clr);
      if (mask_wr) mask_q <= reg_wdata;
    end
  end

  assign src       = {evt_q, lvl_q};
  assign irq       = |(src & mask_q);
  assign reg_rdata = reg_sel ? src : mask_q;

  p_irq_needs_mask_r1: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (mask_q != '0));
  p_tx_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level < tx_empty_mark) |=> src[0]);
  p_tx_ok_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level >= tx_empty_mark) |=> !src[0]);
  p_rx_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_level > rx_full_mark) |=> src[1]);
  p_ibi_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ibi_level > ibi_full_mark) |=> src[2]);
  p_lvl_autoclr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_level <= rx_full_mark) |=> !src[1]);
  p_receipt_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    receipt_evt |=> src[3]);
  p_ibi_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ibi_evt |=> src[4]);
  p_addr_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    addr_req_evt |=> src[5]);
  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (src[3] && !(reg_wr && reg_sel && reg_wdata[3])) |=> src[3]);
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel && reg_wdata[4] && !ibi_evt) |=> !src[4]);
  p_evt_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel && reg_wdata[5] && addr_req_evt) |=> src[5]);
  p_mask_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_sel) |=> (mask_q == $past(reg_wdata)));
endmodule

// File: tb/irq_collector_test.sv
`timescale 1ns/100ps
module irq_collector_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] tx_level = 8'd10, tx_empty_mark = 8'd4;
  logic [7:0] rx_level = 8'd0, rx_full_mark = 8'd8;
  logic [7:0] ibi_level = 8'd0, ibi_full_mark = 8'd8;
  logic       receipt_evt = 1'b0, ibi_evt = 1'b0, addr_req_evt = 1'b0;
  logic       reg_sel = 1'b0, reg_wr = 1'b0;
  logic [5:0] reg_wdata = '0;
  logic [5:0] reg_rdata;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic       sel;
    logic [5:0] data;
    logic       irq;
    string      tag;
  } item_t;
  item_t q[$];

  always #2.5 clk = ~clk;

  irq_collector #(.LVL_W(8)) uut (
    .clk(clk), .rst_n(rst_n),
    .tx_level(tx_level), .tx_empty_mark(tx_empty_mark),
    .rx_level(rx_level), .rx_full_mark(rx_full_mark),
    .ibi_level(ibi_level), .ibi_full_mark(ibi_full_mark),
    .receipt_evt(receipt_evt), .ibi_evt(ibi_evt), .addr_req_evt(addr_req_evt),
    .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (reg_rdata !== it.data || irq !== it.irq) begin
        errors++;
        $display("FAIL %s: sel=%0b rdata=%b irq=%b expected rdata=%b irq=%b",
                 it.tag, it.sel, reg_rdata, irq, it.data, it.irq);
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic look(input logic sel, input logic [5:0] d, input logic i, input string tag);
    item_t it;
    reg_sel = sel;
    it.sel = sel; it.data = d; it.irq = i; it.tag = tag;
    q.push_back(it);
    @(negedge clk);
    #1;
  endtask

  task automatic wr(input logic sel, input logic [5:0] d);
    reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
    tick();
    reg_wr = 1'b0;
  endtask

  initial begin
    repeat (3) tick();
    look(1'b1, 6'h00, 1'b0, "R11 pending in reset");
    rst_n = 1'b1;
    tick();
    look(1'b0, 6'h00, 1'b0, "R11 mask after reset");
    look(1'b1, 6'h00, 1'b0, "R11 pending after reset");

    tx_level = 8'd3; tick();
    look(1'b1, 6'b000001, 1'b0, "R2 below mark, R10 raw while masked");
    tx_level = 8'd4; tick();
    look(1'b1, 6'b000000, 1'b0, "R2 equal to mark");

    rx_level = 8'd9; tick();
    look(1'b1, 6'b000010, 1'b0, "R3 rx above mark");
    rx_level = 8'd8; ibi_level = 8'd9; tick();
    look(1'b1, 6'b000100, 1'b0, "R3 rx equal, ibi above");

    wr(1'b0, 6'h3f);
    look(1'b0, 6'h3f, 1'b1, "R10 mask readback, R1 irq");
    wr(1'b1, 6'b000111);
    look(1'b1, 6'b000100, 1'b1, "R4 write-one ignored on level bit");
    ibi_level = 8'd8; tick();
    look(1'b1, 6'b000000, 1'b0, "R4 auto clear, R1 irq low");

    receipt_evt = 1'b1; tick(); receipt_evt = 1'b0;
    look(1'b1, 6'b001000, 1'b1, "R5 receipt sets bit 3");
    repeat (4) tick();
    look(1'b1, 6'b001000, 1'b1, "R8 bit held");
    wr(1'b1, 6'b110000);
    look(1'b1, 6'b001000, 1'b1, "R8 zero write keeps bit");
    wr(1'b1, 6'b001000);
    look(1'b1, 6'b000000, 1'b0, "R8 write-one clears");

    ibi_evt = 1'b1; tick(); ibi_evt = 1'b0;
    look(1'b1, 6'b010000, 1'b1, "R6 ibi sets bit 4");
    addr_req_evt = 1'b1; tick(); addr_req_evt = 1'b0;
    look(1'b1, 6'b110000, 1'b1, "R7 address request sets bit 5");

    wr(1'b0, 6'b010000);
    look(1'b0, 6'b010000, 1'b1, "R1 one unmasked source");
    wr(1'b0, 6'b000001);
    look(1'b1, 6'b110000, 1'b0, "R10 raw pending, R1 masked");

    wr(1'b1, 6'b010000);
    look(1'b1, 6'b100000, 1'b0, "R8 clear bit 4 only");
    addr_req_evt = 1'b1;
    wr(1'b1, 6'b100000);
    addr_req_evt = 1'b0;
    look(1'b1, 6'b100000, 1'b0, "R9 event wins over clear");
    wr(1'b1, 6'b100000);
    look(1'b1, 6'b000000, 1'b0, "R9 later clear takes effect");

    wr(1'b0, 6'h3f);
    tx_level = 8'd0; receipt_evt = 1'b1; tick(); receipt_evt = 1'b0;
    look(1'b1, 6'b001001, 1'b1, "R1 mixed sources");
    rst_n = 1'b0; tick();
    look(1'b0, 6'h00, 1'b0, "R11 mask cleared by reset");
    look(1'b1, 6'h00, 1'b0, "R11 pending cleared by reset");
    rst_n = 1'b1;
    tick();
    look(1'b1, 6'b000001, 1'b0, "R11 source masked after reset");

    tick();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: expected end of run, got timeout");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule